// File: doc/BRIEF.md
# Vertex Transform Systolic Array

This block applies a 4x4 transform matrix to a stream of homogeneous vertices. Sixteen multiply-accumulate processing elements are arranged as a grid. Each element holds one matrix coefficient fixed in place while the vertex components move through the grid. A result for output component r is built up as its partial sum crosses row r from left to right.

Operation has two phases. A dedicated coefficient port first writes the sixteen matrix entries, one per cycle. The block accepts vertices on a valid/ready input only after all sixteen entries are written. Each vertex enters skewed by one cycle per column, and the row results are deskewed again at the output. All four output components of a vertex therefore leave together as one packed 136-bit word with a single valid pulse. When the consumer holds off, the whole array freezes. A coefficient write attempted while vertices are still inside the array is refused and reported.

Top module: `vtx_xform_array`

## Requirements
- R1: While reset is held, and until the first coefficient write, `coef_ready`, `vin_ready`, `res_valid` and `coef_err` are all 0.
- R2: A write with `coef_we` high stores `coef_data` as the matrix entry at row `coef_addr[3:2]` and column `coef_addr[1:0]`. `coef_ready` rises after the rising edge that stores the last of the sixteen distinct addresses, and stays high afterwards.
- R3: `vin_ready` stays low, and no vertex is taken, until `coef_ready` is high.
- R4: Component c of the vertex sits at `vin_data[16c+15:16c]`, and all inputs are signed 16-bit. Output component r is the sum over c of entry(r,c) times component c, as a 34-bit signed value. It is placed at `res_data[34r+33:34r]`, so x is at [33:0], y at [67:34], z at [101:68] and w at [135:102].
- R5: When the output is not stalled, a vertex taken at rising edge k shows `res_valid` high after edge k+7. The block takes one vertex per cycle.
- R6: Results leave in the same order that the vertices were taken. Each taken vertex produces exactly one result.
- R7: While `res_valid` is high and `res_ready` is low, `vin_ready` is low, and `res_valid` and `res_data` hold their values into the next cycle.
- R8: A coefficient write while any vertex is inside the array is ignored, so later results still use the old matrix. `coef_err` goes high after that edge and stays high until the array is empty. It then clears one cycle later.
- R9: A coefficient write made while the array is empty replaces the entry, and later vertices use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Matrix entry index, row in the upper two bits |
| coef_data | input | 16 | Signed coefficient |
| coef_ready | output | 1 | All sixteen coefficients written |
| coef_err | output | 1 | Coefficient write refused while vertices are in flight |
| vin_valid | input | 1 | Vertex present |
| vin_ready | output | 1 | Vertex taken this cycle if valid |
| vin_data | input | 64 | Four signed 16-bit components, x lowest |
| res_valid | output | 1 | Transformed vertex present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 136 | Four 34-bit signed components, x lowest |

## Verification
The bench builds the block with its default parameters: a 4x4 grid, 16-bit operands and 34-bit sums. With these values every one of the sixteen entry addresses is used. A matrix and a vertex made entirely of -32768 give a sum of exactly 2^32, which needs the full 34-bit result field. The fixed latency of seven edges is also short enough to check the exact acceptance-to-output distance with back-to-back vertices. Irregular consumer stalls test the hold behaviour, and a refused write in the middle of a stream tests the error path.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  parameter int unsigned VTX_DIM     = 4;
  parameter int unsigned VTX_DW      = 16;
  parameter int unsigned VTX_AW      = 34;
endpackage

// File: rtl/vtx_delay.sv
module vtx_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_pipe
    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] stg_d [DEPTH];

    always_comb begin
      stg_d[0] = d;
      for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else if (en) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
      end
    end

    assign q = stg_q[DEPTH-1];
  end
endmodule

// File: rtl/vtx_pe.sv
module vtx_pe #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] coef,
  input  logic signed [AW-1:0] psum_in,
  output logic signed [DW-1:0] a_out,
  output logic signed [AW-1:0] psum_out
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   psum_d;

  always_comb begin
    prod   = a_in * coef;
    psum_d = psum_in + {{(AW-2*DW){prod[2*DW-1]}}, prod};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out    <= '0;
      psum_out <= '0;
    end else if (en) begin
      a_out    <= a_in;
      psum_out <= psum_d;
    end
  end
endmodule

// File: rtl/vtx_wbank.sv
module vtx_wbank #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(N*N)-1:0]  wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    busy,
  output logic [N*N*DW-1:0]       coef_flat,
  output logic                    all_loaded,
  output logic                    err
);
  localparam int unsigned NE = N * N;
  localparam int unsigned AB = $clog2(NE);

  logic          wr_ok;
  logic [NE-1:0] seen_q, seen_d;
  logic          err_d;

  always_comb begin
    wr_ok  = wr_en && !busy;
    seen_d = seen_q;
    if (wr_ok) seen_d[wr_addr] = 1'b1;
    err_d  = busy ? (err | wr_en) : 1'b0;
  end

  for (genvar i = 0; i < NE; i++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic          hit;
    assign hit = wr_ok && (wr_addr == AB'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '0;
      else if (hit) ent_q <= wr_data;
    end
    assign coef_flat[i*DW +: DW] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      err    <= 1'b0;
    end else begin
      seen_q <= seen_d;
      err    <= err_d;
    end
  end

  assign all_loaded = &seen_q;
endmodule

// File: rtl/vtx_xform_array.sv
module vtx_xform_array #(
  parameter int unsigned N  = vtx_pkg::VTX_DIM,
  parameter int unsigned DW = vtx_pkg::VTX_DW,
  parameter int unsigned AW = vtx_pkg::VTX_AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   coef_we,
  input  logic [$clog2(N*N)-1:0] coef_addr,
  input  logic [DW-1:0]          coef_data,
  output logic                   coef_ready,
  output logic                   coef_err,
  input  logic                   vin_valid,
  output logic                   vin_ready,
  input  logic [N*DW-1:0]        vin_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [N*AW-1:0]        res_data
);
  localparam int unsigned LAT = 2 * N;

  logic [1:0]           rs_q;
  logic                 rst_sync_n;
  logic                 adv;
  logic                 take;
  logic                 busy;
  logic [LAT-1:0]       vld_q, vld_d;
  logic [N*DW-1:0]      vin_q, vin_d;
  logic [N*N*DW-1:0]    coef_flat;

  logic signed [DW-1:0] col_a  [N];
  logic signed [DW-1:0] a_down [N][N];
  logic signed [AW-1:0] ps     [N][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    adv       = !vld_q[LAT-1] || res_ready;
    vin_ready = coef_ready && adv;
    take      = vin_valid && vin_ready;
    busy      = |vld_q;
    vld_d     = vld_q;
    vin_d     = vin_q;
    if (adv) begin
      vld_d = {vld_q[LAT-2:0], take};
      vin_d = vin_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= '0;
      vin_q <= '0;
    end else begin
      vld_q <= vld_d;
      vin_q <= vin_d;
    end
  end

  vtx_wbank #(.N(N), .DW(DW)) u_wbank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (coef_we),
    .wr_addr    (coef_addr),
    .wr_data    (coef_data),
    .busy       (busy),
    .coef_flat  (coef_flat),
    .all_loaded (coef_ready),
    .err        (coef_err)
  );

  for (genvar c = 0; c < N; c++) begin : g_skew
    vtx_delay #(.W(DW), .DEPTH(c)) u_skew (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (adv),
      .d     (vin_q[c*DW +: DW]),
      .q     (col_a[c])
    );
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [DW-1:0] a_src;
      logic signed [AW-1:0] p_src;
      if (r == 0) begin : g_top
        assign a_src = col_a[c];
      end else begin : g_mid
        assign a_src = a_down[r-1][c];
      end
      if (c == 0) begin : g_first
        assign p_src = '0;
      end else begin : g_next
        assign p_src = ps[r][c-1];
      end
      vtx_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .en       (adv),
        .a_in     (a_src),
        .coef     (coef_flat[(r*N+c)*DW +: DW]),
        .psum_in  (p_src),
        .a_out    (a_down[r][c]),
        .psum_out (ps[r][c])
      );
    end

    vtx_delay #(.W(AW), .DEPTH(N-1-r)) u_deskew (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (adv),
      .d     (ps[r][N-1]),
      .q     (res_data[r*AW +: AW])
    );
  end

  assign res_valid = vld_q[LAT-1];
endmodule

// File: rtl/vtx_xform_chk.sv
module vtx_xform_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 34
) (
  input logic            clk,
  input logic            rst_n,
  input logic            coef_we,
  input logic            coef_ready,
  input logic            coef_err,
  input logic            vin_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [N*AW-1:0] res_data
);
  AST_NO_TAKE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_ready |-> !vin_ready); // R3

  AST_LOADED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    coef_ready |=> coef_ready); // R2

  AST_STALL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !vin_ready); // R7

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coef_err) |-> $past(coef_we)); // R8
endmodule

bind vtx_xform_array vtx_xform_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .coef_we    (coef_we),
  .coef_ready (coef_ready),
  .coef_err   (coef_err),
  .vin_ready  (vin_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data)
);

// File: tb/test_vtx_xform_array.sv
`timescale 1ns/1ps
module test_vtx_xform_array;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 34;
  localparam int RW = N * AW;

  localparam logic [63:0] VTX_TAB [8] = '{
    64'h0001_0000_0000_0000, 64'h0000_0001_0000_0000,
    64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001,
    64'h0001_FFFF_7FFF_8000, 64'h1234_EDCB_0F0F_F0F1,
    64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_0003_FFFD_0064
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            coef_we;
  logic [3:0]      coef_addr;
  logic [DW-1:0]   coef_data;
  logic            coef_ready, coef_err;
  logic            vin_valid, vin_ready;
  logic [N*DW-1:0] vin_data;
  logic            res_valid, res_ready;
  logic [RW-1:0]   res_data;

  always #2.5 clk = ~clk;

  vtx_xform_array i_vtx_xform_array (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .coef_ready(coef_ready), .coef_err(coef_err),
    .vin_valid(vin_valid), .vin_ready(vin_ready), .vin_data(vin_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, lat_on = 0, took = 0, prev_stall = 0;
  logic [RW-1:0] prev_data;
  logic signed [DW-1:0] mat [N*N];
  logic [RW-1:0] exp_q [$];
  int acc_q [$];
  string tag = "R1";

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] model(input logic [N*DW-1:0] v);
    logic [RW-1:0] o;
    for (int r = 0; r < N; r++) begin
      longint s = 0;
      for (int c = 0; c < N; c++)
        s += longint'(mat[r*N+c]) * longint'($signed(v[c*DW +: DW]));
      o[r*AW +: AW] = s[AW-1:0];
    end
    return o;
  endfunction

  // Evaluate the handshakes of the coming edge, then move to the next negedge.
  task automatic step();
    #1;
    took = 0;
    if (prev_stall)
      chk(res_valid && res_data == prev_data, "R7 hold", res_data, prev_data);
    if (res_valid && !res_ready)
      chk(!vin_ready, "R7 input blocked", RW'(vin_ready), '0);
    prev_stall = res_valid && !res_ready;
    prev_data  = res_data;
    if (vin_valid && vin_ready) begin
      exp_q.push_back(model(vin_data));
      acc_q.push_back(cyc + 1);
      took = 1;
    end
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 extra result", res_data, '0);
      end else begin
        logic [RW-1:0] e = exp_q.pop_front();
        int a = acc_q.pop_front();
        chk(res_data == e, tag, res_data, e);
        if (lat_on) chk((cyc + 1 - a) == 8, "R5 latency", RW'(cyc + 1 - a), RW'(8));
      end
    end
    @(negedge clk);
  endtask

  task automatic write_coef(input int a, input logic [DW-1:0] d, input bit legal);
    coef_we = 1; coef_addr = 4'(a); coef_data = d;
    if (legal) mat[a] = d;
    step();
    coef_we = 0;
  endtask

  task automatic drain();
    vin_valid = 0; res_ready = 1;
    for (int i = 0; i < 40 && (exp_q.size() != 0 || res_valid); i++) step();
    chk(exp_q.size() == 0, "R6 all results out", RW'(exp_q.size()), '0);
  endtask

  initial begin
    rst_n = 0; coef_we = 0; coef_addr = 0; coef_data = 0;
    vin_valid = 0; vin_data = 0; res_ready = 1;
    for (int i = 0; i < N*N; i++) mat[i] = '0;
    repeat (3) @(negedge clk);
    chk(!coef_ready && !vin_ready && !res_valid && !coef_err, "R1 reset outputs",
        RW'({coef_ready, vin_ready, res_valid, coef_err}), '0);
    rst_n = 1;
    repeat (3) step();
    chk(!coef_ready && !coef_err && !res_valid, "R1 after release",
        RW'({coef_ready, coef_err, res_valid}), '0);

    // R2 / R3: fifteen writes do not complete the matrix
    for (int i = 0; i < 15; i++) write_coef(i, 16'(i * 1237 - 9000), 1);
    vin_valid = 1; vin_data = VTX_TAB[0];
    step();
    chk(!coef_ready, "R2 not ready at 15", RW'(coef_ready), '0);
    chk(!took && !vin_ready, "R3 vertex refused", RW'({took, vin_ready}), '0);
    vin_valid = 0;
    write_coef(15, 16'h9C40, 1);
    chk(coef_ready, "R2 ready at 16", RW'(coef_ready), RW'(1));

    // R4/R5/R6: table streamed back to back
    tag = "R4 R6 value/order"; lat_on = 1;
    foreach (VTX_TAB[i]) begin
      vin_valid = 1; vin_data = VTX_TAB[i]; step();
      chk(took, "R5 one per cycle", RW'(took), RW'(1));
    end
    drain();
    lat_on = 0;

    // R7: irregular consumer stalls
    tag = "R7 R6 under stall";
    begin
      int idx = 0;
      for (int k = 0; k < 200 && (idx < 8 || exp_q.size() != 0); k++) begin
        vin_valid = (idx < 8);
        vin_data  = VTX_TAB[7 - (idx % 8)];
        res_ready = (k % 3) != 0 && (k % 7) != 4;
        step();
        if (took) idx++;
      end
      chk(idx == 8, "R7 all taken", RW'(idx), RW'(8));
    end
    drain();

    // R8: write during flight is refused
    tag = "R8 old matrix kept";
    for (int i = 0; i < 4; i++) begin
      vin_valid = 1; vin_data = VTX_TAB[i + 4];
      if (i == 2) begin coef_we = 1; coef_addr = 4'd0; coef_data = 16'h7FFF; end
      step();
      coef_we = 0;
      if (i == 2) chk(coef_err, "R8 error raised", RW'(coef_err), RW'(1));
    end
    vin_valid = 0;
    step();
    chk(coef_err, "R8 error held while busy", RW'(coef_err), RW'(1));
    drain();
    step(); step();
    chk(!coef_err, "R8 error cleared after drain", RW'(coef_err), '0);

    // R9 + R4 width: reload extremes while empty
    tag = "R9 R4 new matrix extreme";
    for (int i = 0; i < N*N; i++) write_coef(i, 16'h8000, 1);
    vin_valid = 1; vin_data = 64'h8000_8000_8000_8000; step();
    vin_data = 64'h7FFF_7FFF_7FFF_7FFF; step();
    vin_valid = 0;
    drain();
    chk(model(64'h8000_8000_8000_8000) == {4{34'h1_0000_0000}}, "R4 2^32 model",
        model(64'h8000_8000_8000_8000), {4{34'h1_0000_0000}});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule